// File: doc/BRIEF.md
# Integer Scheduler Dispatch Steering

This block sits between register renaming and four integer scheduling queues. Every cycle it looks at up to `LANES` renamed micro-ops, oldest in lane 0, and gives each one a destination queue according to its operation class. Generic ALU and multiply ops rotate across all four queues through a round-robin pointer. Branches rotate over the three queues that hold a branch port. Pointer-authentication and predicate ops can only go to the last queue. An integer multiply-add is split into two halves, and each half goes to its own multiply-capable queue.

The destination is fixed before the block looks at free space. If the chosen queue is full, the op waits and so does every younger op behind it, even when some other queue could have taken it. Each queue keeps an occupancy count. The count rises by the number of entries dispatched into the queue. It falls by one for each of the queue's two issue ports that drains an entry in that cycle. Upstream logic reads `disp_valid`, removes the dispatched prefix from the group, and presents the remaining ops again starting at lane 0.

Top module: `int_sched_steer`

## Requirements
- R1: After reset, every queue occupancy reads zero, and both the round-robin pointer and the branch pointer point at queue 0.
- R2: Class codes 0 (ALU) and 1 (multiply), and the spare codes 6 and 7, go to the queue the round-robin pointer selects. Each such op that dispatches moves the pointer forward by one, wrapping from 3 to 0. Later lanes in the same cycle continue the sequence.
- R3: Dispatch stays in order. `disp_valid` is always a prefix of the lanes. A lane that cannot dispatch also holds back every younger lane, even a lane whose own target has room.
- R4: Branches (class 2) go to queues 0, 1 and 2 in turn, using a separate pointer. They never move the round-robin pointer.
- R5: Pointer-authentication ops (class 3) and predicate ops (class 4) always go to queue 3. They move neither pointer.
- R6: A multiply-add (class 5) sets `disp_pair`. Its first half goes to the round-robin queue and its second half to the next queue, modulo 4. The pointer moves forward by two. Both halves dispatch in the same cycle, or neither does.
- R7: The target queue is chosen before room is checked. An op stalls when its target's occupancy plus the entries already given to it in the same cycle reaches `QDEPTH`. No other queue is tried, and the pointer does not move.
- R8: Next occupancy = current occupancy − drained + dispatched. The room check uses the occupancy at the start of the cycle, so entries drained in a cycle do not free room until the next cycle. Occupancy never exceeds `QDEPTH`.
- R9: Each queue has two drain bits in `q_drain`, bits [2q+1:2q], one per issue port. Each set bit removes one entry. Drain bits beyond the current occupancy are ignored, so the count stops at zero.
- R10: The occupancy of queue q appears on `q_occ[q*OCCW +: OCCW]`. The targets of lane i appear on `disp_qa[2i+1:2i]` and `disp_qb[2i+1:2i]`. The class of lane i is `op_class[3i+2:3i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | LANES | Lane holds a micro-op (lane 0 oldest) |
| op_class | input | 3*LANES | Operation class per lane |
| q_drain | input | 8 | Per-queue, per-issue-port drain strobes |
| disp_valid | output | LANES | Lane dispatched this cycle (prefix) |
| disp_qa | output | 2*LANES | Target queue of the op or its first half |
| disp_qb | output | 2*LANES | Target queue of the second multiply-add half |
| disp_pair | output | LANES | Lane is a split multiply-add |
| q_occ | output | 4*OCCW | Occupancy count per queue |

## Verification
The bench builds the block with `LANES` = 4 and `QDEPTH` = 5. The small depth lets a handful of ops fill a queue. That makes full-queue stalls, blocking of younger ops behind a full target, and waits on queue 3 for class-restricted ops occur early in a short, directed sequence. A long pseudo-random class mix with random drain strobes then pushes two allocations into one queue in the same cycle, uses drains that exceed occupancy, and keeps multiply-add pairs wrapping past queue 3.

// File: rtl/int_sched_steer.sv
module int_sched_steer #(
  parameter int LANES = 4,
  parameter int QDEPTH = 28,
  localparam int OCCW = $clog2(QDEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    op_valid,
  input  logic [LANES*3-1:0]  op_class,
  input  logic [7:0]          q_drain,
  output logic [LANES-1:0]    disp_valid,
  output logic [LANES*2-1:0]  disp_qa,
  output logic [LANES*2-1:0]  disp_qb,
  output logic [LANES-1:0]    disp_pair,
  output logic [4*OCCW-1:0]   q_occ
);
  localparam int AW = $clog2(2 * LANES + 1);
  localparam logic [2:0] C_BR = 3'd2, C_PAC = 3'd3, C_PRED = 3'd4, C_MADD = 3'd5;

  logic [OCCW-1:0] occ [4];
  logic [OCCW-1:0] drn [4];
  logic [AW-1:0]   alloc [4];
  logic [1:0]      rr_q, rr_d, br_q, br_d;

  always_comb begin
    logic       blk, pair, fit;
    logic [1:0] qa, qb;
    logic [2:0] c;
    rr_d = rr_q;
    br_d = br_q;
    blk  = 1'b0;
    for (int q = 0; q < 4; q++) alloc[q] = '0;
    for (int i = 0; i < LANES; i++) begin
      c    = op_class[i*3 +: 3];
      qb   = 2'd0;
      pair = 1'b0;
      case (c)
        C_BR:          qa = br_d;
        C_PAC, C_PRED: qa = 2'd3;
        C_MADD: begin
          qa   = rr_d;
          qb   = rr_d + 2'd1;
          pair = 1'b1;
        end
        default:       qa = rr_d;
      endcase
      fit = (int'(occ[qa]) + int'(alloc[qa]) < QDEPTH) &&
            (!pair || (int'(occ[qb]) + int'(alloc[qb]) < QDEPTH));
      disp_valid[i]      = op_valid[i] && !blk && fit;
      disp_qa[i*2 +: 2]  = qa;
      disp_qb[i*2 +: 2]  = qb;
      disp_pair[i]       = pair;
      blk = blk || !disp_valid[i];
      if (disp_valid[i]) begin
        alloc[qa] = alloc[qa] + AW'(1);
        if (pair) alloc[qb] = alloc[qb] + AW'(1);
        case (c)
          C_BR:          br_d = (br_d == 2'd2) ? 2'd0 : br_d + 2'd1;
          C_PAC, C_PRED: ;
          C_MADD:        rr_d = rr_d + 2'd2;
          default:       rr_d = rr_d + 2'd1;
        endcase
      end
    end
  end

  always_comb begin
    for (int q = 0; q < 4; q++) begin
      drn[q] = OCCW'(q_drain[2*q]) + OCCW'(q_drain[2*q+1]);
      if (drn[q] > occ[q]) drn[q] = occ[q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
      br_q <= '0;
      for (int q = 0; q < 4; q++) occ[q] <= '0;
    end else begin
      rr_q <= rr_d;
      br_q <= br_d;
      for (int q = 0; q < 4; q++) occ[q] <= occ[q] - drn[q] + OCCW'(alloc[q]);
    end
  end

  for (genvar q = 0; q < 4; q++) begin : g_q
    assign q_occ[q*OCCW +: OCCW] = occ[q];

    p_occ_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ[q]) <= QDEPTH);

    p_occ_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid == '0 && q_drain[2*q +: 2] == 2'b00) |=> $stable(occ[q]));
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    p_branch_q_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid[i] && op_class[i*3 +: 3] == C_BR) |-> disp_qa[i*2 +: 2] != 2'd3);

    p_q3_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid[i] && (op_class[i*3 +: 3] == C_PAC || op_class[i*3 +: 3] == C_PRED))
        |-> disp_qa[i*2 +: 2] == 2'd3);

    p_madd_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid[i] && op_class[i*3 +: 3] == C_MADD)
        |-> (disp_pair[i] && disp_qb[i*2 +: 2] == disp_qa[i*2 +: 2] + 2'd1));

    if (i > 0) begin : g_ord
      p_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid[i] |-> disp_valid[i-1]);
    end
  end
endmodule

// File: tb/tb_int_sched_steer.sv
`timescale 1ns/1ps
module tb_int_sched_steer;
  localparam int LANES = 4;
  localparam int QD = 5;
  localparam int OCCW = $clog2(QD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0]   op_valid = '0;
  logic [LANES*3-1:0] op_class = '0;
  logic [7:0]         drn = '0;
  logic [LANES-1:0]   disp_valid;
  logic [LANES*2-1:0] disp_qa, disp_qb;
  logic [LANES-1:0]   disp_pair;
  logic [4*OCCW-1:0]  q_occ;

  int checks = 0, fails = 0;
  bit started = 0, done = 0, rnd_drain = 0;
  int cls_q[$], exp_a[$], exp_b[$];
  int rr = 0, br = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  int_sched_steer #(.LANES(LANES), .QDEPTH(QD)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .q_drain(drn), .disp_valid(disp_valid), .disp_qa(disp_qa),
    .disp_qb(disp_qb), .disp_pair(disp_pair), .q_occ(q_occ));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int c);
    case (c)
      2:       return "R4 branch target";
      3, 4:    return "R5 queue-3 target";
      5:       return "R6 multiply-add pair";
      default: return "R2 round-robin target";
    endcase
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // driver side: expected targets follow only from the op order
  task automatic push(int c);
    int a, b;
    b = -1;
    case (c)
      2: begin a = br; br = (br + 1) % 3; end
      3, 4: a = 3;
      5: begin a = rr; b = (rr + 1) % 4; rr = (rr + 2) % 4; end
      default: begin a = rr; rr = (rr + 1) % 4; end
    endcase
    cls_q.push_back(c);
    exp_a.push_back(a);
    exp_b.push_back(b);
  endtask

  task automatic wait_idle();
    while (cls_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : drv
    int n;
    wait (started);
    forever begin
      @(negedge clk);
      for (int i = 0; i < LANES; i++) begin
        op_valid[i] = (i < cls_q.size());
        op_class[i*3 +: 3] = (i < cls_q.size()) ? 3'(cls_q[i]) : 3'd0;
      end
      if (rnd_drain) begin
        seed = nxt(seed);
        drn = seed[7:0] & seed[15:8];
      end
      #8;
      n = $countones(disp_valid);
      repeat (n) void'(cls_q.pop_front());
    end
  end

  initial begin : mon
    int mo[4], cnt[4];
    int a, b, n, d;
    bit blk, fit, expd;
    for (int q = 0; q < 4; q++) mo[q] = 0;
    wait (started);
    forever begin
      @(negedge clk);
      #5;
      for (int q = 0; q < 4; q++)
        chk(int'(q_occ[q*OCCW +: OCCW]) == mo[q], "R8 R9 R10 occupancy",
            int'(q_occ[q*OCCW +: OCCW]), mo[q]);
      for (int q = 0; q < 4; q++) cnt[q] = 0;
      blk = 0;
      for (int i = 0; i < LANES; i++) begin
        if (!op_valid[i]) blk = 1;
        else begin
          a = exp_a[i];
          b = exp_b[i];
          fit = (mo[a] + cnt[a] < QD) && (b < 0 || mo[b] + cnt[b] < QD);
          expd = !blk && fit;
          chk(disp_valid[i] == expd, blk ? "R3 in-order block" : "R7 full-target stall",
              int'(disp_valid[i]), int'(expd));
          if (expd && disp_valid[i]) begin
            chk(int'(disp_qa[i*2 +: 2]) == a, tag_of(cls_q[i]), int'(disp_qa[i*2 +: 2]), a);
            chk(disp_pair[i] == (b >= 0), "R6 pair flag", int'(disp_pair[i]), int'(b >= 0));
            if (b >= 0)
              chk(int'(disp_qb[i*2 +: 2]) == b, "R6 second half", int'(disp_qb[i*2 +: 2]), b);
          end
          if (expd) begin
            cnt[a]++;
            if (b >= 0) cnt[b]++;
          end else blk = 1;
        end
      end
      n = $countones(disp_valid);
      repeat (n) begin
        void'(exp_a.pop_front());
        void'(exp_b.pop_front());
      end
      for (int q = 0; q < 4; q++) begin
        d = int'(drn[2*q]) + int'(drn[2*q+1]);
        if (d > mo[q]) d = mo[q];
        mo[q] = mo[q] - d + cnt[q];
      end
    end
  end

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    for (int q = 0; q < 4; q++)
      chk(q_occ[q*OCCW +: OCCW] == '0, "R1 reset occupancy", int'(q_occ[q*OCCW +: OCCW]), 0);
    chk(disp_valid == '0, "R1 idle after reset", int'(disp_valid), 0);
    // R1: both pointers start at queue 0 (the model above starts rr and br at 0)
    started = 1;

    for (int k = 0; k < 4; k++) push(0);
    for (int k = 0; k < 4; k++) push(2);
    push(3); push(4); push(5); push(1);
    wait_idle();

    // fill until queue 0 is full, then an ALU op aimed at it stalls
    for (int k = 0; k < 6; k++) push(0);
    push(2);
    push(3);
    repeat (6) @(negedge clk);
    drn = 8'b0000_0001;
    @(negedge clk);
    drn = 8'b0;
    repeat (4) @(negedge clk);
    drn = 8'hFF;
    repeat (8) @(negedge clk);
    drn = 8'h0;
    wait_idle();

    rnd_drain = 1;
    for (int k = 0; k < 400; k++) begin
      seed = nxt(seed);
      push(int'(seed[2:0]));
    end
    wait_idle();
    rnd_drain = 0;
    drn = 8'hFF;
    repeat (8) @(negedge clk);
    drn = 8'h0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule